// File: doc/BRIEF.md
# IDE Task-File Port Access Decoder

This block sits between a little-endian host I/O bus and the register file of one IDE channel. Every host request names one of two windows: the eight-byte command window or the four-byte control window. It also carries an offset, an access size and a direction. The block checks each request against the offsets and sizes the channel can take. A legal request drives exactly one drive-side strobe for the request cycle: a byte-register strobe, a 16-bit data-port strobe or a 32-bit data-port strobe.

A request the channel cannot take never reaches the register file. If it is a read, the block returns all ones at the width of the access. If it is a write, the block drops it. Every request gets an acknowledge one cycle later, and for reads the registered read data is valid in that same cycle.

The register file answers reads combinationally during the strobe cycle. The decoder registers that answer, trimmed to the access width.

Top module: `ide_port_decoder`

## Requirements
- R1: After reset is released, and before any request, `rsp_ack` is low, `rsp_rdata` is zero and no drive strobe is active.
- R2: In the control window (`req_win`=1), only a byte access (`req_size`=0) at offset 2 is forwarded. A read pulses `rd_byte` and a write pulses `wr_byte`, with `dev_ctl`=1 and `dev_addr`=2.
- R3: A control-window read at any other offset or size drives no strobe. It returns all ones at the access width: 0x000000FF for size 0, 0x0000FFFF for size 1, and 0xFFFFFFFF for size 2 or 3.
- R4: A control-window write at any other offset or size drives no strobe and leaves the register file unchanged.
- R5: In the command window (`req_win`=0), a byte access at any offset 0..7 pulses `rd_byte` or `wr_byte` with `dev_ctl`=0 and `dev_addr` equal to that offset. Read data is the register byte, zero-extended.
- R6: In the command window, a 2-byte access (`req_size`=1) at offset 0 pulses `rd_data16` or `wr_data16`. Read data is the low 16 bits of the port value, zero-extended.
- R7: In the command window, a 4-byte access (`req_size`=2) at offset 0 pulses `rd_data32` or `wr_data32` and moves all 32 bits.
- R8: In the command window, a 2-byte or 4-byte access at a nonzero offset drives no strobe. A read returns all ones at its width, and a write leaves the register file unchanged.
- R9: Size code 3 is reserved in both windows. It drives no strobe, reads 0xFFFFFFFF and drops writes.
- R10: Every request is acknowledged by `rsp_ack` exactly one cycle later, and `rsp_ack` is never high without such a request. `rsp_rdata` is zero on write acknowledges. At most one strobe is active in a cycle, and none is active without a request.
- R11: Data is little-endian. Byte lane 0 carries the lowest-addressed byte. `dev_wdata` carries the write data masked to the access width, so a 16-bit write changes only the low half of the 32-bit port value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request |
| req_win | input | 1 | Window: 0 command, 1 control |
| req_addr | input | 3 | Byte offset inside the window |
| req_size | input | 2 | 0 byte, 1 two bytes, 2 four bytes, 3 reserved |
| req_we | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, lane 0 lowest byte |
| rsp_ack | output | 1 | Acknowledge, one cycle after the request |
| rsp_rdata | output | 32 | Registered read data |
| dev_ctl | output | 1 | Byte strobe targets the control register when 1 |
| dev_addr | output | 3 | Byte register offset |
| dev_wdata | output | 32 | Width-masked write data |
| dev_rdata | input | 32 | Register file read data during a read strobe |
| rd_byte | output | 1 | Byte register read strobe |
| wr_byte | output | 1 | Byte register write strobe |
| rd_data16 | output | 1 | 16-bit data port read strobe |
| wr_data16 | output | 1 | 16-bit data port write strobe |
| rd_data32 | output | 1 | 32-bit data port read strobe |
| wr_data32 | output | 1 | 32-bit data port write strobe |

## Verification
The bench walks every offset of both windows with every size code. It goes after a control window that also takes neighbouring offsets, or wraps offset 6 onto offset 2. Such a design would strobe the device-control register and corrupt the alternate status read back later.

It also targets multi-byte accesses at nonzero command offsets and the reserved size code. A decoder that ignored the offset there would pulse a data-port strobe and change the 32-bit port value that a later read returns. A wrong fill width on rejected reads shows up as 0xFF where 0xFFFF is due, or the reverse. Finally, a 16-bit write followed by a 32-bit read exposes a design that lets the upper lanes through or swaps the byte order.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_BYTE = 2'd1,
    K_D16  = 2'd2,
    K_D32  = 2'd3
  } port_kind_e;

  // All-ones value at the width of an access; reserved size is full width.
  function automatic logic [31:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_mask = 32'h0000_00FF;
      SZ_HALF: width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ide_access_qual.sv
module ide_access_qual
  import ide_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CTL_OFF = 2
) (
  input  logic              valid,
  input  logic              win,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output port_kind_e        kind
);

  localparam logic [ADDR_W-1:0] ZERO_OFF = '0;

  always_comb begin
    kind = K_NONE;
    if (valid) begin
      if (win) begin
        // control window: a single byte register
        if ((addr == CTL_OFF) && (size == SZ_BYTE)) kind = K_BYTE;
      end else begin
        case (size)
          SZ_BYTE: kind = K_BYTE;
          SZ_HALF: if (addr == ZERO_OFF) kind = K_D16;
          SZ_WORD: if (addr == ZERO_OFF) kind = K_D32;
          default: kind = K_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ide_strobe_drv.sv
module ide_strobe_drv
  import ide_dec_pkg::*;
(
  input  port_kind_e kind,
  input  logic       we,
  output logic       rd_byte,
  output logic       wr_byte,
  output logic       rd_data16,
  output logic       wr_data16,
  output logic       rd_data32,
  output logic       wr_data32
);

  always_comb begin
    rd_byte   = 1'b0;
    wr_byte   = 1'b0;
    rd_data16 = 1'b0;
    wr_data16 = 1'b0;
    rd_data32 = 1'b0;
    wr_data32 = 1'b0;
    case (kind)
      K_BYTE:  if (we) wr_byte   = 1'b1; else rd_byte   = 1'b1;
      K_D16:   if (we) wr_data16 = 1'b1; else rd_data16 = 1'b1;
      K_D32:   if (we) wr_data32 = 1'b1; else rd_data32 = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/ide_read_fmt.sv
module ide_read_fmt
  import ide_dec_pkg::*;
(
  input  port_kind_e  kind,
  input  logic [1:0]  size,
  input  logic [31:0] dev_rdata,
  output logic [31:0] fmt_data
);

  always_comb begin
    case (kind)
      K_BYTE:  fmt_data = {24'h0, dev_rdata[7:0]};
      K_D16:   fmt_data = {16'h0, dev_rdata[15:0]};
      K_D32:   fmt_data = dev_rdata;
      default: fmt_data = width_mask(size);  // rejected read floats high
    endcase
  end

endmodule

// File: rtl/ide_port_decoder.sv
module ide_port_decoder
  import ide_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter logic [ADDR_W-1:0] CTL_OFF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_win,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_we,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ack,
  output logic [31:0]       rsp_rdata,
  output logic              dev_ctl,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [31:0]       dev_wdata,
  input  logic [31:0]       dev_rdata,
  output logic              rd_byte,
  output logic              wr_byte,
  output logic              rd_data16,
  output logic              wr_data16,
  output logic              rd_data32,
  output logic              wr_data32
);

  port_kind_e  kind;
  logic [31:0] fmt_data;
  logic        ack_d, ack_q;
  logic [31:0] rdata_d, rdata_q;
  logic        any_stb;

  ide_access_qual #(.ADDR_W(ADDR_W), .CTL_OFF(CTL_OFF)) u_qual (
    .valid (req_valid),
    .win   (req_win),
    .addr  (req_addr),
    .size  (req_size),
    .kind  (kind)
  );

  ide_strobe_drv u_stb (
    .kind      (kind),
    .we        (req_we),
    .rd_byte   (rd_byte),
    .wr_byte   (wr_byte),
    .rd_data16 (rd_data16),
    .wr_data16 (wr_data16),
    .rd_data32 (rd_data32),
    .wr_data32 (wr_data32)
  );

  ide_read_fmt u_fmt (
    .kind      (kind),
    .size      (req_size),
    .dev_rdata (dev_rdata),
    .fmt_data  (fmt_data)
  );

  assign dev_ctl   = req_win;
  assign dev_addr  = req_addr;
  assign dev_wdata = req_wdata & width_mask(req_size);

  // next-state
  always_comb begin
    ack_d   = req_valid;
    rdata_d = rdata_q;
    if (req_valid) rdata_d = req_we ? 32'h0 : fmt_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= 32'h0;
    end else begin
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_ack   = ack_q;
  assign rsp_rdata = rdata_q;

  assign any_stb = rd_byte | wr_byte | rd_data16 | wr_data16 | rd_data32 | wr_data32;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_byte, wr_byte, rd_data16, wr_data16, rd_data32, wr_data32})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !any_stb); // R10
  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ack); // R10
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ack); // R10
  AST_CTL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_win && any_stb) |-> (req_addr == CTL_OFF && req_size == SZ_BYTE && (rd_byte || wr_byte))); // R2
  AST_PORT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data16 || wr_data16 || rd_data32 || wr_data32) |-> (!req_win && req_addr == '0)); // R6
  AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == SZ_RSVD) |-> !any_stb); // R9
  AST_REJECT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && !any_stb) |=> (rsp_rdata == width_mask($past(req_size)))); // R3

endmodule

// File: tb/ide_port_decoder_tb.sv
module ide_port_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_win = 1'b0, req_we = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ack, dev_ctl;
  logic [31:0] rsp_rdata, dev_wdata, dev_rdata;
  logic [2:0]  dev_addr;
  logic        rd_byte, wr_byte, rd_data16, wr_data16, rd_data32, wr_data32;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_port_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
    .req_addr(req_addr), .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .dev_ctl(dev_ctl), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .rd_byte(rd_byte), .wr_byte(wr_byte),
    .rd_data16(rd_data16), .wr_data16(wr_data16), .rd_data32(rd_data32), .wr_data32(wr_data32)
  );

  // Drive register file model, changed only by strobes
  logic [7:0]  m_cmd [8];
  logic [7:0]  m_devctl;
  logic [31:0] m_port;

  always_comb begin
    dev_rdata = 32'hDEAD_BEEF;
    if (rd_byte) dev_rdata = dev_ctl ? {24'hABCDEF, m_devctl ^ 8'hA5} : {24'h123456, m_cmd[dev_addr]};
    else if (rd_data16 || rd_data32) dev_rdata = m_port;
  end

  always_ff @(posedge clk) begin
    if (wr_byte) begin
      if (dev_ctl) m_devctl <= dev_wdata[7:0];
      else m_cmd[dev_addr] <= dev_wdata[7:0];
    end
    if (wr_data16) m_port[15:0] <= dev_wdata[15:0];
    if (wr_data32) m_port <= dev_wdata;
  end

  // Expected shadow, updated from the requirements
  logic [7:0]  s_cmd [8];
  logic [7:0]  s_devctl;
  logic [31:0] s_port;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ones(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // strobe code: 0 none, 1 rd_byte, 2 wr_byte, 3 rd16, 4 wr16, 5 rd32, 6 wr32
  task automatic acc(input bit win, input logic [2:0] a, input logic [1:0] sz,
                     input bit we, input logic [31:0] wd, input string tag);
    int kind;  // 0 none, 1 byte, 2 d16, 3 d32
    int code;
    int act;
    logic [31:0] exp;
    item_t it;
    kind = 0;
    if (win) begin
      if (a == 3'd2 && sz == 2'd0) kind = 1;
    end else if (sz == 2'd0) kind = 1;
    else if (sz == 2'd1 && a == 3'd0) kind = 2;
    else if (sz == 2'd2 && a == 3'd0) kind = 3;
    code = (kind == 0) ? 0 : (kind * 2 - (we ? 0 : 1));
    if (we) exp = 32'h0;
    else case (kind)
      1: exp = win ? {24'h0, s_devctl ^ 8'hA5} : {24'h0, s_cmd[a]};
      2: exp = {16'h0, s_port[15:0]};
      3: exp = s_port;
      default: exp = ones(sz);
    endcase
    if (we) case (kind)
      1: if (win) s_devctl = wd[7:0]; else s_cmd[a] = wd[7:0];
      2: s_port[15:0] = wd[15:0];
      3: s_port = wd;
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_win = win; req_addr = a; req_size = sz; req_we = we; req_wdata = wd;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    #1;
    act = rd_byte ? 1 : wr_byte ? 2 : rd_data16 ? 3 : wr_data16 ? 4 : rd_data32 ? 5 : wr_data32 ? 6 : 0;
    check((act == code) && ($countones({rd_byte, wr_byte, rd_data16, wr_data16, rd_data32, wr_data32}) <= 1),
          {tag, " strobe"}, act, code);
    if (kind == 1)
      check(dev_ctl == win && dev_addr == a, {tag, " dev_addr"}, {28'h0, dev_ctl, dev_addr}, {28'h0, win, a});
    if (we && kind != 0)
      check(dev_wdata == (wd & ones(sz)), "R11 dev_wdata mask", dev_wdata, wd & ones(sz));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected items as acknowledges arrive
  always @(negedge clk) begin
    if (rst_n && rsp_ack) begin
      if (sb_q.size() == 0) check(1'b0, "R10 ack without request", 32'h1, 32'h0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(rsp_rdata == it.exp, it.tag, rsp_rdata, it.exp);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(1'b0, "watchdog expired", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_cmd[i] = 8'h10 + 8'(i); s_cmd[i] = 8'h10 + 8'(i); end
    m_devctl = 8'h00; s_devctl = 8'h00;
    m_port = 32'h0; s_port = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_ack == 1'b0 && rsp_rdata == 32'h0, "R1 reset outputs", rsp_rdata, 32'h0);
    check(!(rd_byte | wr_byte | rd_data16 | wr_data16 | rd_data32 | wr_data32), "R1 reset strobes", 32'h1, 32'h0);

    // R5 byte registers at every command offset
    for (int i = 0; i < 8; i++) acc(1'b0, 3'(i), 2'd0, 1'b1, 32'hFFFF_FF00 | (32'h40 + i), "R5 byte write");
    for (int i = 0; i < 8; i++) acc(1'b0, 3'(i), 2'd0, 1'b0, 32'h0, "R5 byte read");

    // R7 / R6 / R11 data port, back to back
    acc(1'b0, 3'd0, 2'd2, 1'b1, 32'h1122_3344, "R7 write32");
    acc(1'b0, 3'd0, 2'd2, 1'b0, 32'h0, "R7 read32");
    acc(1'b0, 3'd0, 2'd1, 1'b0, 32'h0, "R6 read16");
    acc(1'b0, 3'd0, 2'd1, 1'b1, 32'h5566_BEEF, "R6 write16");
    acc(1'b0, 3'd0, 2'd2, 1'b0, 32'h0, "R11 read32 after write16");
    idle(2);
    check(rsp_ack == 1'b0, "R10 ack low when idle", {31'h0, rsp_ack}, 32'h0);

    // R8 multi-byte at nonzero command offsets
    for (int i = 1; i < 8; i++) begin
      acc(1'b0, 3'(i), 2'd1, 1'b0, 32'h0, "R8 read16 offset");
      acc(1'b0, 3'(i), 2'd2, 1'b0, 32'h0, "R8 read32 offset");
      acc(1'b0, 3'(i), 2'd1, 1'b1, 32'hA5A5_A5A5, "R8 write16 dropped");
      acc(1'b0, 3'(i), 2'd2, 1'b1, 32'h5A5A_5A5A, "R8 write32 dropped");
    end
    acc(1'b0, 3'd0, 2'd2, 1'b0, 32'h0, "R8 port unchanged");
    for (int i = 0; i < 8; i++) acc(1'b0, 3'(i), 2'd0, 1'b0, 32'h0, "R8 bytes unchanged");

    // R9 reserved size in both windows
    acc(1'b0, 3'd0, 2'd3, 1'b0, 32'h0, "R9 reserved read cmd");
    acc(1'b0, 3'd0, 2'd3, 1'b1, 32'h0BAD_0BAD, "R9 reserved write cmd");
    acc(1'b1, 3'd2, 2'd3, 1'b0, 32'h0, "R9 reserved read ctl");
    acc(1'b1, 3'd2, 2'd3, 1'b1, 32'h0BAD_0BAD, "R9 reserved write ctl");
    acc(1'b0, 3'd0, 2'd2, 1'b0, 32'h0, "R9 port unchanged");

    // R2 control register
    acc(1'b1, 3'd2, 2'd0, 1'b1, 32'h0000_0006, "R2 ctl write");
    acc(1'b1, 3'd2, 2'd0, 1'b0, 32'h0, "R2 ctl read");

    // R3 / R4 other control offsets and sizes
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 3; s++) begin
        if (!(i == 2 && s == 0)) begin
          acc(1'b1, 3'(i), 2'(s), 1'b0, 32'h0, "R3 ctl reject read");
          acc(1'b1, 3'(i), 2'(s), 1'b1, 32'hFFFF_FF3C, "R4 ctl write dropped");
        end
      end
    end
    acc(1'b1, 3'd2, 2'd0, 1'b0, 32'h0, "R4 ctl register unchanged");
    idle(3);
    check(sb_q.size() == 0, "R10 every request acknowledged", sb_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule